// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

The controller gathers five interrupt sources (video reset, vertical, horizontal, command and PWM). It holds one pending latch for each source and keeps an enable mask. It presents one prioritized request to a CPU as a request line and a 3-bit level. Software clears pending state with one strobe per source. The mask is written and read through a small register port, and the same port reads back the pending bits.

Masking has a different effect depending on the source. For video reset, vertical, horizontal and PWM, a source that has already latched keeps requesting after its mask bit is cleared, and it stops only when it is cleared. The command source is gated by its mask at the output. While it is masked its request drops, but its pending latch stays set. Setting the mask bit again brings the request back until software clears it.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the mask is 0, all pending bits are 0, irq_o is 0 and level_o is 0.
- R2: A one-cycle event on evt_i[i] sets pending bit i only if mask bit i is 1 in that same cycle. Bit order is 0 PWM, 1 command, 2 horizontal, 3 vertical, 4 video reset.
- R3: A pending video reset, vertical, horizontal or PWM bit keeps requesting while its mask bit is 0. Its pending bit stays set until its clear strobe is applied.
- R4: A pending command bit (bit 1) makes no request while mask bit 1 is 0. Its pending bit stays set.
- R5: When mask bit 1 is set again while the command bit is still pending, the command request reappears.
- R6: A clear strobe on clr_i[i] resets pending bit i on the next edge. This happens even if an event on the same source arrives in the same cycle.
- R7: level_o is the active source with the highest priority: 5 video reset, 4 vertical, 3 horizontal, 2 command, 1 PWM, 0 none. irq_o is 1 exactly when level_o is not 0.
- R8: Address 0 reads and writes the mask. Address 1 reads the pending bits. A write to address 1 has no effect, and reads never change any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Source event pulses |
| clr_i | input | 5 | Per-source pending clear strobes |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 1 | Register address (0 mask, 1 pending) |
| wdata_i | input | 5 | Register write data |
| rdata_o | output | 5 | Register read data |
| irq_o | output | 1 | Interrupt request |
| level_o | output | 3 | Encoded priority level of the request |

## Verification
The bench builds the block with its default parameters: five sources and a register port five bits wide. This keeps the space small enough to sweep every mask value against every event pattern. Each pair is then followed by a remask, which lets the bench compare the gated command source with the sticky sources in every priority combination. Directed sequences then cover the command re-enable, clear-versus-event collisions and the ignored write to the pending register.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int NSRC    = 5;
  localparam int LVL_W   = $clog2(NSRC + 1);
  localparam int SRC_PWM = 0;
  localparam int SRC_CMD = 1;
  localparam int SRC_HRZ = 2;
  localparam int SRC_VRT = 3;
  localparam int SRC_VRS = 4;
  // sources whose request is gated by the mask at the output
  localparam logic [NSRC-1:0] GATED_SRC = NSRC'(1) << SRC_CMD;
  localparam logic ADDR_MASK = 1'b0;
  localparam logic ADDR_PEND = 1'b1;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NSRC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int              NSRC  = 5,
  parameter logic [NSRC-1:0] GATED = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] req_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     pend_o[i] <= 1'b0;
      else if (clr_i[i])               pend_o[i] <= 1'b0;  // clear beats event
      else if (evt_i[i] && mask_i[i])  pend_o[i] <= 1'b1;
    end
    if (GATED[i]) begin : g_gated
      assign req_o[i] = pend_o[i] & mask_i[i];
    end else begin : g_sticky
      assign req_o[i] = pend_o[i];
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NSRC  = 5,
  parameter int LVL_W = 3
) (
  input  logic [NSRC-1:0]  req_i,
  output logic [LVL_W-1:0] level_o
);
  // highest index wins, level = index + 1
  always_comb begin
    level_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i]) level_o = LVL_W'(i + 1);
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  evt_i,
  input  logic [NSRC-1:0]  clr_i,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [NSRC-1:0]  wdata_i,
  output logic [NSRC-1:0]  rdata_o,
  output logic             irq_o,
  output logic [LVL_W-1:0] level_o
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] req;
  logic            mask_wr;

  assign mask_wr = wr_en_i && (addr_i == ADDR_MASK);

  irq_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (mask_wr),
    .wdata_i(wdata_i),
    .mask_o (mask_q)
  );

  irq_pend_bank #(.NSRC(NSRC), .GATED(GATED_SRC)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr_i),
    .mask_i (mask_q),
    .pend_o (pend_q),
    .req_o  (req)
  );

  irq_prio_enc #(.NSRC(NSRC), .LVL_W(LVL_W)) u_enc (
    .req_i  (req),
    .level_o(level_o)
  );

  assign irq_o   = |req;
  assign rdata_o = (addr_i == ADDR_PEND) ? pend_q : mask_q;
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
  import irq_pend_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSRC-1:0]  evt_i,
  input logic [NSRC-1:0]  clr_i,
  input logic [NSRC-1:0]  mask_i,
  input logic [NSRC-1:0]  pend_i,
  input logic             irq_i,
  input logic [LVL_W-1:0] level_i
);
  localparam logic [NSRC-1:0] CMD_BIT = NSRC'(1) << SRC_CMD;

  AST_SET_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_i & ~$past(pend_i) & ~($past(evt_i) & $past(mask_i))) == '0)); // R2
  AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_i) & ~$past(clr_i)) & ~pend_i) == '0)); // R3
  AST_CMD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[SRC_CMD] && !mask_i[SRC_CMD] && ((pend_i & ~CMD_BIT) == '0)) |-> !irq_i); // R4
  AST_CMD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[SRC_CMD] && mask_i[SRC_CMD]) |-> (irq_i && level_i >= LVL_W'(SRC_CMD + 1))); // R5
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((pend_i & $past(clr_i)) == '0)); // R6
  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i <= LVL_W'(NSRC)) && (irq_i == (level_i != '0))); // R7
endmodule

bind irq_pend_ctrl irq_pend_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .evt_i  (evt_i),
  .clr_i  (clr_i),
  .mask_i (mask_q),
  .pend_i (pend_q),
  .irq_i  (irq_o),
  .level_i(level_o)
);

// File: tb/irq_pend_ctrl_test.sv
module irq_pend_ctrl_test;
  import irq_pend_pkg::*;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NSRC-1:0]  evt_i = '0;
  logic [NSRC-1:0]  clr_i = '0;
  logic             wr_en_i = 1'b0;
  logic             addr_i = 1'b0;
  logic [NSRC-1:0]  wdata_i = '0;
  logic [NSRC-1:0]  rdata_o;
  logic             irq_o;
  logic [LVL_W-1:0] level_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  irq_pend_ctrl uut (.*);

  function automatic int exp_level(logic [4:0] p, logic [4:0] m);
    for (int i = 4; i >= 0; i--) begin
      if (p[i] && (i != 1 || m[1])) return i + 1;
    end
    return 0;
  endfunction

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr_mask(logic [4:0] m);
    wr_en_i = 1'b1; addr_i = 1'b0; wdata_i = m;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic a, output logic [4:0] v);
    addr_i = a; #0.1; v = rdata_o;
  endtask

  task automatic chk_out(string req, logic [4:0] p, logic [4:0] m);
    logic [4:0] v;
    int lv;
    lv = exp_level(p, m);
    rd(1'b1, v);
    chk({req, " pend"}, v, p);
    chk({req, " level"}, level_o, lv);
    chk({req, " irq"}, irq_o, lv != 0);
  endtask

  initial begin
    logic [4:0] v;
    logic [4:0] m2;
    repeat (3) tick();
    // R1 reset state
    rd(1'b0, v);
    chk("R1 mask", v, 0);
    chk_out("R1", 5'd0, 5'd0);
    rst_ni = 1'b1;
    tick();

    // R2 R3 R4 R5 R7 sweep: every mask x event pattern, then remask
    for (int m = 0; m < 32; m++) begin
      for (int e = 0; e < 32; e++) begin
        clr_i = 5'h1f; tick(); clr_i = '0;
        wr_mask(5'(m));
        evt_i = 5'(e); tick(); evt_i = '0;
        chk_out("R2 R7", 5'(e & m), 5'(m));
        m2 = 5'(m) ^ 5'((e * 5 + 3) & 31);
        wr_mask(m2);
        chk_out("R3 R4 R5", 5'(e & m), m2);
      end
    end

    // R4 R5 command re-enable sequence
    clr_i = 5'h1f; tick(); clr_i = '0;
    wr_mask(5'h1f);
    evt_i = 5'b00010; tick(); evt_i = '0;
    chk("R5 level on", level_o, 2);
    wr_mask(5'h00);
    chk("R4 irq masked", irq_o, 0);
    rd(1'b1, v); chk("R4 pend kept", v, 5'b00010);
    repeat (4) tick();
    chk("R4 still masked", level_o, 0);
    wr_mask(5'b00010);
    chk("R5 reasserted", level_o, 2);
    clr_i = 5'b00010; tick(); clr_i = '0;
    chk("R6 cmd cleared", irq_o, 0);

    // R3 sticky PWM while masked
    wr_mask(5'h1f);
    evt_i = 5'b00001; tick(); evt_i = '0;
    wr_mask(5'h00);
    repeat (3) tick();
    chk("R3 pwm sticky", level_o, 1);

    // R6 clear vs event same cycle
    wr_mask(5'h1f);
    evt_i = 5'h1f; clr_i = 5'h1f; tick(); evt_i = '0; clr_i = '0;
    chk_out("R6 collide", 5'd0, 5'h1f);
    for (int i = 0; i < 5; i++) begin
      evt_i = 5'h1f; tick(); evt_i = '0;
      clr_i = 5'(1 << i); tick(); clr_i = '0;
      chk_out("R6 single", 5'h1f & ~5'(1 << i), 5'h1f);
    end

    // R8 pending register is read-only, reads change nothing
    evt_i = 5'b10100; tick(); evt_i = '0;
    chk_out("R8 setup", 5'h1f, 5'h1f);
    wr_en_i = 1'b1; addr_i = 1'b1; wdata_i = 5'h00; tick(); wr_en_i = 1'b0;
    chk_out("R8 write ignored", 5'h1f, 5'h1f);
    rd(1'b0, v); chk("R8 mask intact", v, 5'h1f);
    wr_mask(5'b01010);
    rd(1'b0, v); chk("R8 mask readback", v, 5'b01010);
    repeat (3) begin rd(1'b1, v); tick(); end
    chk_out("R8 read no effect", 5'h1f, 5'b01010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule